// File: doc/BRIEF.md
# Multi-Chain Logic Self-Test Controller

This block runs a pseudo-random logic self-test over a set of parallel scan chains. One linear feedback shift register (LFSR) produces the stimulus. Each chain takes its serial input from a different stage of that register, so the chains receive streams that are offset in phase from one another. The responses coming out of the chains pass through a per-chain mask and are folded into a multiple-input signature register (MISR). When the programmed number of patterns has been applied, the block compares the signature it has built with the expected value it was given and reports pass or fail.

The sequence for each pattern is a load of chain-length shift cycles followed by a single capture cycle. The unload of each response overlaps the load of the next stimulus. A final unload-only pass empties the last response. A chain whose output cannot be predicted, for example one that starts from an unknown state or holds an unknown capture, is masked. Its output then reaches the signature as a constant zero. Pseudo-random stimulus is good at finding easy faults. Logic that needs rare value combinations can stay untested, so this block is meant to sit next to a deterministic pattern source and not to replace one.

The scan path moves in lockstep with the controller. There is no valid/ready handshake and no back-pressure: a chain shifts on every cycle in which scan enable is high, and the circuit under test must accept a bit on every such cycle.

Top module: `lbist_engine`

## Requirements
- R1: A start pulse seen while the block is idle begins a run. It loads the LFSR with the seed 16'hACE1, clears the signature to zero, and latches the pattern count, the chain mask and the expected signature. A start pulse seen during a run has no effect.
- R2: A run with pattern count P has (P+1) shift phases of CHAIN_LEN cycles each, with scan enable high, and one capture cycle with scan enable low between consecutive shift phases. One compare cycle with scan enable low follows. The done output is high on the cycle that comes (P+1)*CHAIN_LEN + P + 1 clock edges after the edge that accepted start.
- R3: During every shift cycle, the serial input of chain c equals LFSR bit 4*c (stride = SIG_W / N_CHAINS). The LFSR steps once per shift cycle in Galois form: the state shifts right, and when bit 0 was 1 the result is XORed with 16'hB400. In all other cycles the LFSR holds its value.
- R4: The signature register compacts only on shift cycles that come after at least one capture, so the first load of a run is never compacted. Each step shifts right with the same 16'hB400 feedback, then XORs the output of chain c into bit 4*c.
- R5: A chain whose mask bit is 1 feeds 0 into the signature whatever its scan output carries. Bit c of the mask applies to chain c.
- R6: After the compare cycle, done is 1 and pass is 1 exactly when the final signature equals the latched expected value. Both hold until the next accepted start, which drives both to 0 from the following cycle.
- R7: A pattern count of 0 gives a single uncompacted load phase. The signature stays 0, so pass is 1 only when the expected value is 0.
- R8: Changing the pattern count, mask or expected value during a run has no effect on that run's timing or result.
- R9: After reset, done, pass and scan enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a run when the block is idle |
| pat_count_i | input | PAT_W | Number of patterns to apply |
| chain_mask_i | input | N_CHAINS | A 1 removes that chain's output from the signature |
| expect_sig_i | input | SIG_W | Signature expected for a good circuit |
| scan_en_o | output | 1 | High on shift cycles, low on capture and idle cycles |
| scan_in_o | output | N_CHAINS | Serial stimulus, one bit per chain |
| scan_out_i | input | N_CHAINS | Serial response, one bit per chain |
| done_o | output | 1 | The run has completed |
| pass_o | output | 1 | The signature matched; valid while done is high |

## Verification
The hardest condition to reach is a run in which a masked chain carries arbitrary, changing values on its scan output while the unmasked chains carry genuine responses. Only then does a leak through the mask, or compaction during the first load, show up as a wrong pass result. The bench models the circuit under test as a set of shift registers with a nonlinear capture function. It drives fresh random bits on masked outputs every cycle and starts each run from chain contents left over by the previous run. A separate run changes every latched input and pulses start in the middle of the sequence.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_CAPT  = 2'd2,
    PH_CHECK = 2'd3
  } phase_e;
endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
  parameter int          SIG_W    = 16,
  parameter int          N_CHAINS = 4,
  parameter logic [15:0] POLY     = 16'hB400,
  parameter logic [15:0] SEED     = 16'hACE1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                adv_i,
  output logic [N_CHAINS-1:0] taps_o
);
  localparam int STRIDE = SIG_W / N_CHAINS;

  logic [SIG_W-1:0] state_q;
  logic [SIG_W-1:0] state_nx;

  always_comb begin
    state_nx = {1'b0, state_q[SIG_W-1:1]};
    if (state_q[0]) state_nx = state_nx ^ SIG_W'(POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= SIG_W'(SEED);
    else if (load_i) state_q <= SIG_W'(SEED);
    else if (adv_i)  state_q <= state_nx;
  end

  for (genvar g = 0; g < N_CHAINS; g++) begin : g_tap
    assign taps_o[g] = state_q[g*STRIDE];
  end

  AST_PRPG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R3
  AST_PRPG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(state_q)); // R3
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int          SIG_W    = 16,
  parameter int          N_CHAINS = 4,
  parameter logic [15:0] POLY     = 16'hB400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                en_i,
  input  logic [N_CHAINS-1:0] data_i,
  output logic [SIG_W-1:0]    sig_o
);
  localparam int STRIDE = SIG_W / N_CHAINS;

  logic [SIG_W-1:0] sig_q;
  logic [SIG_W-1:0] inject;
  logic [SIG_W-1:0] sig_nx;

  always_comb begin
    inject = '0;
    for (int c = 0; c < N_CHAINS; c++) inject[c*STRIDE] = data_i[c];
    sig_nx = {1'b0, sig_q[SIG_W-1:1]};
    if (sig_q[0]) sig_nx = sig_nx ^ SIG_W'(POLY);
    sig_nx = sig_nx ^ inject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig_q <= '0;
    else if (clr_i) sig_q <= '0;
    else if (en_i)  sig_q <= sig_nx;
  end

  assign sig_o = sig_q;

  AST_MISR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_i) |=> $stable(sig_q)); // R4
  AST_MISR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sig_q == '0)); // R1
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PAT_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PAT_W-1:0] pat_count_i,
  output logic             accept_o,
  output logic             shift_o,
  output logic             compact_o,
  output logic             check_o
);
  localparam int BW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(CHAIN_LEN - 1);

  phase_e           ph_q;
  logic [BW-1:0]    bit_q;
  logic [PAT_W-1:0] done_pat_q;
  logic [PAT_W-1:0] total_q;

  assign accept_o  = (ph_q == PH_IDLE) && start_i;
  assign shift_o   = (ph_q == PH_SHIFT);
  assign compact_o = shift_o && (done_pat_q != '0);
  assign check_o   = (ph_q == PH_CHECK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      bit_q      <= '0;
      done_pat_q <= '0;
      total_q    <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q       <= PH_SHIFT;
          bit_q      <= '0;
          done_pat_q <= '0;
          total_q    <= pat_count_i;
        end
        PH_SHIFT: if (bit_q == LAST_BIT) begin
          bit_q <= '0;
          ph_q  <= (done_pat_q == total_q) ? PH_CHECK : PH_CAPT;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
        PH_CAPT: begin
          done_pat_q <= done_pat_q + 1'b1;
          ph_q       <= PH_SHIFT;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  AST_CAPT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_CAPT) |=> (ph_q == PH_SHIFT)); // R2
  AST_CHECK_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_CHECK) |-> ($past(ph_q) == PH_SHIFT)); // R2
  AST_PAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |-> (done_pat_q <= total_q)); // R2
endmodule

// File: rtl/lbist_engine.sv
module lbist_engine #(
  parameter int          N_CHAINS  = 4,
  parameter int          CHAIN_LEN = 8,
  parameter int          SIG_W     = 16,
  parameter int          PAT_W     = 12,
  parameter logic [15:0] POLY      = 16'hB400,
  parameter logic [15:0] SEED      = 16'hACE1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [PAT_W-1:0]    pat_count_i,
  input  logic [N_CHAINS-1:0] chain_mask_i,
  input  logic [SIG_W-1:0]    expect_sig_i,
  output logic                scan_en_o,
  output logic [N_CHAINS-1:0] scan_in_o,
  input  logic [N_CHAINS-1:0] scan_out_i,
  output logic                done_o,
  output logic                pass_o
);
  logic                accept;
  logic                shift;
  logic                compact;
  logic                check;
  logic [N_CHAINS-1:0] mask_q;
  logic [SIG_W-1:0]    expect_q;
  logic [SIG_W-1:0]    sig;
  logic                done_q;
  logic                pass_q;

  lbist_seq #(.CHAIN_LEN(CHAIN_LEN), .PAT_W(PAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pat_count_i(pat_count_i),
    .accept_o(accept), .shift_o(shift), .compact_o(compact), .check_o(check)
  );

  lbist_prpg #(.SIG_W(SIG_W), .N_CHAINS(N_CHAINS), .POLY(POLY), .SEED(SEED)) u_prpg (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .adv_i(shift), .taps_o(scan_in_o)
  );

  lbist_misr #(.SIG_W(SIG_W), .N_CHAINS(N_CHAINS), .POLY(POLY)) u_misr (
    .clk(clk), .rst_n(rst_n), .clr_i(accept), .en_i(compact),
    .data_i(scan_out_i & ~mask_q), .sig_o(sig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      expect_q <= '0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
    end else if (accept) begin
      mask_q   <= chain_mask_i;
      expect_q <= expect_sig_i;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
    end else if (check) begin
      done_q   <= 1'b1;
      pass_q   <= (sig == expect_q);
    end
  end

  assign scan_en_o = shift;
  assign done_o    = done_q;
  assign pass_o    = pass_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!done_o && !pass_o)); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o); // R6
  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> done_o); // R6
  AST_NO_SHIFT_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en_o |-> !done_o); // R2
endmodule

// File: tb/test_lbist_engine.sv
module test_lbist_engine;
  localparam int N = 4;
  localparam int L = 8;
  localparam int W = 16;
  localparam int PW = 12;
  localparam int STR = W / N;
  localparam logic [15:0] POLY = 16'hB400;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PW-1:0] pcnt = '0;
  logic [N-1:0] mask = '0;
  logic [W-1:0] expv = '0;
  logic scan_en;
  logic [N-1:0] scan_in;
  logic [N-1:0] scan_out;
  logic done;
  logic pass;

  logic [N-1:0][L-1:0] chains = '0;
  logic [N-1:0] xsel = '0;
  logic [N-1:0] xbits = '0;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lbist_engine #(.N_CHAINS(N), .CHAIN_LEN(L), .SIG_W(W), .PAT_W(PW),
                 .POLY(POLY), .SEED(SEED)) i_lbist_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pat_count_i(pcnt),
    .chain_mask_i(mask), .expect_sig_i(expv), .scan_en_o(scan_en),
    .scan_in_o(scan_in), .scan_out_i(scan_out), .done_o(done), .pass_o(pass)
  );

  function automatic logic [N-1:0][L-1:0] cut_capture(logic [N-1:0][L-1:0] ch);
    logic [N-1:0][L-1:0] nx;
    for (int c = 0; c < N; c++)
      nx[c] = (ch[c] & ch[(c+1)%N]) ^ {ch[c][L-2:0], ch[c][L-1]} ^ ch[(c+3)%N];
    return nx;
  endfunction

  function automatic logic [W-1:0] galois(logic [W-1:0] s);
    logic [W-1:0] r;
    r = {1'b0, s[W-1:1]};
    if (s[0]) r = r ^ W'(POLY);
    return r;
  endfunction

  function automatic logic [W-1:0] ref_sig(int p, logic [N-1:0] m);
    logic [N-1:0][L-1:0] ch;
    logic [W-1:0] lf;
    logic [W-1:0] sg;
    logic [W-1:0] inj;
    ch = '0;
    lf = W'(SEED);
    sg = '0;
    for (int ph = 0; ph <= p; ph++) begin
      for (int b = 0; b < L; b++) begin
        if (ph > 0) begin
          inj = '0;
          for (int c = 0; c < N; c++) inj[c*STR] = ch[c][L-1] & ~m[c];
          sg = galois(sg) ^ inj;
        end
        for (int c = 0; c < N; c++) ch[c] = {ch[c][L-2:0], lf[c*STR]};
        lf = galois(lf);
      end
      if (ph < p) ch = cut_capture(ch);
    end
    return sg;
  endfunction

  always @(posedge clk) begin
    if (scan_en) begin
      for (int c = 0; c < N; c++) chains[c] <= {chains[c][L-2:0], scan_in[c]};
    end else begin
      chains <= cut_capture(chains);
    end
  end

  always @(negedge clk) xbits <= N'($urandom);

  always_comb begin
    for (int c = 0; c < N; c++) scan_out[c] = xsel[c] ? xbits[c] : chains[c][L-1];
  end

  task automatic check(bit ok, string req, string what, int act, int exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
    end
  endtask

  // Runs one test. If disturb is set, the inputs are changed and start is pulsed mid-run.
  task automatic run(int p, logic [N-1:0] m, logic [N-1:0] xs, bit good, bit disturb);
    logic [W-1:0] r;
    logic [W-1:0] lf;
    int cyc, ones, zeros, bad_stream, t_exp;
    r = ref_sig(p, m);
    @(negedge clk);
    pcnt = PW'(p);
    mask = m;
    xsel = xs;
    expv = good ? r : (r ^ W'(1 << $urandom_range(0, W-1)));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lf = W'(SEED);
    cyc = 1; ones = 0; zeros = 0; bad_stream = 0;
    t_exp = (p + 1) * L + p + 2;
    while (!done && cyc < 20000) begin
      if (scan_en) begin
        ones++;
        for (int c = 0; c < N; c++) if (scan_in[c] !== lf[c*STR]) bad_stream++;
        lf = galois(lf);
      end else begin
        zeros++;
      end
      if (disturb && cyc == 3) begin
        pcnt = PW'(p + 5);
        mask = ~m;
        expv = ~expv;
        start = 1'b1;
      end
      if (disturb && cyc == 4) start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    check(cyc == t_exp, disturb ? "R8" : "R2", "cycles to done", cyc, t_exp);
    check(ones == (p + 1) * L, "R2", "shift cycle count", ones, (p + 1) * L);
    check(zeros == p + 1, "R2", "non-shift cycle count", zeros, p + 1);
    check(bad_stream == 0, "R3", "chain stimulus mismatches", bad_stream, 0);
    check(done === 1'b1 && pass === good,
          (xs != 0) ? "R5" : (disturb ? "R1" : "R4"), "pass result", pass, good);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(done === 1'b0, "R9", "done after reset", done, 0);
    check(pass === 1'b0, "R9", "pass after reset", pass, 0);
    check(scan_en === 1'b0, "R9", "scan_en after reset", scan_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(scan_en === 1'b0, "R9", "scan_en idle", scan_en, 0);

    run(1, 4'b0000, 4'b0000, 1'b1, 1'b0);   // R2 R3 R4 single pattern
    run(3, 4'b0000, 4'b0000, 1'b0, 1'b0);   // R6 wrong expected -> fail
    // R7: zero patterns, signature is zero
    check(ref_sig(0, '0) == '0, "R7", "reference zero signature", ref_sig(0, '0), 0);
    run(0, 4'b0000, 4'b0000, 1'b1, 1'b0);   // R7
    run(0, 4'b0000, 4'b0000, 1'b0, 1'b0);   // R7 nonzero expected fails
    run(5, 4'b0101, 4'b0101, 1'b1, 1'b0);   // R5 masked chains carry garbage
    run(4, 4'b1111, 4'b1111, 1'b1, 1'b0);   // R5 all masked
    run(6, 4'b0010, 4'b0010, 1'b1, 1'b1);   // R8 R1 disturbance mid-run

    // R6: result holds while idle
    repeat (6) @(negedge clk);
    check(done === 1'b1 && pass === 1'b1, "R6", "result held", {done, pass}, 3);

    for (int i = 0; i < 10; i++) begin
      int p;
      logic [N-1:0] m;
      p = $urandom_range(1, 12);
      m = N'($urandom);
      run(p, m, m & N'($urandom), ($urandom % 4) != 0, 1'b0);
    end

    // R1: after an accepted start, done and pass drop on the next cycle
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b0 && pass === 1'b0, "R1", "cleared by start", {done, pass}, 0);
    while (!done) @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule